// File: doc/BRIEF.md
# Per-Line DMA Transaction Controller

This block sits between a DMA request stream and a memory channel, and it tracks line transactions that are in flight. Each valid entry in a small table holds a line address and the transient state of that line: an outstanding read or an outstanding write. A request for a line with no entry is given an entry and goes out to memory. A request for a line that already has an entry, or a request that arrives while every entry is taken, is not sent. It is parked in an in-order holding queue instead.

A memory response is matched against the table. A data response completes a read, and an acknowledge completes a write. On completion the entry is freed, a one-cycle notification carrying the line address goes upstream, and the parked queue wakes. Parked requests are then replayed from the head of the queue, one per cycle. Replay stops at the first request that is still blocked, and the next completion restarts it.

Top module: `dma_line_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `mem_valid`, `cb_valid` and `resp_err` are low and `req_ready` is high.
- R2: A request to a line with no entry is accepted. The cycle after acceptance, `mem_valid` is high with `mem_line` equal to the request line and `mem_write` equal to the request's write flag (1 = write). For a write, `mem_wdata` carries the request data.
- R3: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_line` and `mem_write` hold their values. The slot empties on the cycle after `mem_ready` is sampled high.
- R4: A response with `rsp_is_data` = 1 for a line with an outstanding read causes `cb_valid` to go high the next cycle. At that point `cb_write` = 0, `cb_line` is the response line and `cb_data` is the response data.
- R5: A response with `rsp_is_data` = 0 for a line with an outstanding write causes `cb_valid` to go high the next cycle, with `cb_write` = 1 and `cb_line` equal to the response line.
- R6: A request for a line that has an outstanding read or write is accepted but parked. No memory request is issued for it until that line's transaction completes.
- R7: When all ENTRIES table entries are in use, a request for a line with no entry is parked. It is issued on the cycle after the next completion.
- R8: A response for a line with no entry, or a response whose type does not match the line's outstanding operation, makes `resp_err` high for exactly the next cycle. Such a response produces no notification and leaves the entry outstanding.
- R9: After a completion, parked requests are issued in arrival order, at most one per cycle, starting the cycle after the completion. Replay halts at the first request whose line is still busy, and the requests behind it stay parked even if their lines are free.
- R10: `cb_valid` is high for one cycle per completing response and never without a response on the previous cycle.
- R11: Once a transaction completes, its line has no entry, and a later request to that line is issued directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (issued or parked) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_line | input | LINE_W | Request line address |
| req_wdata | input | DATA_W | Write data |
| mem_valid | output | 1 | Memory request slot full |
| mem_ready | input | 1 | Memory takes the slot |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_line | output | LINE_W | Memory request line |
| mem_wdata | output | DATA_W | Memory write data |
| rsp_valid | input | 1 | Response present |
| rsp_ready | output | 1 | Response taken (always high) |
| rsp_is_data | input | 1 | 1 = read data, 0 = write acknowledge |
| rsp_line | input | LINE_W | Response line |
| rsp_data | input | DATA_W | Read data |
| cb_valid | output | 1 | One-cycle completion notice |
| cb_write | output | 1 | Completed operation was a write |
| cb_line | output | LINE_W | Completed line |
| cb_data | output | DATA_W | Read data (zero for writes) |
| resp_err | output | 1 | One-cycle unmatched-response flag |

## Verification
An accepted request appears on the memory slot one edge later. A response produces its notification or error flag one edge later. The first parked request is replayed on the second edge after the completing response, and each further replay follows one edge after the previous one. The bench drives every input just after a rising edge and samples the outputs one time unit after the edge where the result is due. It walks long parked sequences edge by edge and checks both the cycles where something must issue and the cycles where nothing may.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  typedef enum logic [1:0] {
    LN_IDLE    = 2'd0,
    LN_RD_WAIT = 2'd1,
    LN_WR_WAIT = 2'd2
  } line_st_e;
endpackage

// File: rtl/dlc_line_table.sv
module dlc_line_table
  import dlc_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_en,
  input  logic                     alloc_write,
  input  logic [LINE_W-1:0]        alloc_line,
  input  logic                     free_en,
  input  logic [$clog2(ENTRIES > 1 ? ENTRIES : 2)-1:0] free_idx,
  input  logic [LINE_W-1:0]        qa_line,
  output logic                     qa_busy,
  input  logic [LINE_W-1:0]        qr_line,
  output logic                     qr_hit,
  output logic [$clog2(ENTRIES > 1 ? ENTRIES : 2)-1:0] qr_idx,
  output line_st_e                 qr_state,
  output logic                     full
);
  localparam int IDX_W = $clog2(ENTRIES > 1 ? ENTRIES : 2);

  logic [ENTRIES-1:0] vld;
  line_st_e           st [ENTRIES];
  logic [LINE_W-1:0]  ln [ENTRIES];
  logic [IDX_W-1:0]   alloc_idx;

  always_comb begin
    alloc_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) alloc_idx = IDX_W'(i);
    end
  end

  assign full = &vld;

  always_comb begin
    qa_busy  = 1'b0;
    qr_hit   = 1'b0;
    qr_idx   = '0;
    qr_state = LN_IDLE;
    for (int i = 0; i < ENTRIES; i++) begin
      if (vld[i] && ln[i] == qa_line) qa_busy = 1'b1;
      if (vld[i] && ln[i] == qr_line) begin
        qr_hit   = 1'b1;
        qr_idx   = IDX_W'(i);
        qr_state = st[i];
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic do_alloc, do_free;
    assign do_alloc = alloc_en && (alloc_idx == IDX_W'(g));
    assign do_free  = free_en && (free_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld[g] <= 1'b0;
        st[g]  <= LN_IDLE;
        ln[g]  <= '0;
      end else if (do_alloc) begin
        vld[g] <= 1'b1;
        st[g]  <= alloc_write ? LN_WR_WAIT : LN_RD_WAIT;
        ln[g]  <= alloc_line;
      end else if (do_free) begin
        vld[g] <= 1'b0;
        st[g]  <= LN_IDLE;
      end
    end
  end
endmodule

// File: rtl/dlc_park_fifo.sv
module dlc_park_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = $clog2(DEPTH > 1 ? DEPTH : 2);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign head  = mem[rp];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && wp == PW'(g)) mem[g] <= push_data;
    end
  end
endmodule

// File: rtl/dma_line_ctrl.sv
module dma_line_ctrl
  import dlc_pkg::*;
#(
  parameter int LINE_W     = 16,
  parameter int DATA_W     = 32,
  parameter int ENTRIES    = 4,
  parameter int PARK_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [LINE_W-1:0] req_line,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [LINE_W-1:0] mem_line,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic              rsp_is_data,
  input  logic [LINE_W-1:0] rsp_line,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              cb_valid,
  output logic              cb_write,
  output logic [LINE_W-1:0] cb_line,
  output logic [DATA_W-1:0] cb_data,
  output logic              resp_err
);
  localparam int IDX_W = $clog2(ENTRIES > 1 ? ENTRIES : 2);
  localparam int PK_W  = 1 + LINE_W + DATA_W;

  // parked queue
  logic              pk_push, pk_pop, pk_empty, pk_full;
  logic [PK_W-1:0]   pk_head;
  logic              h_write;
  logic [LINE_W-1:0] h_line;
  logic [DATA_W-1:0] h_wdata;
  assign {h_write, h_line, h_wdata} = pk_head;

  // table
  logic              qa_busy, qr_hit, tbl_full;
  logic [IDX_W-1:0]  qr_idx;
  line_st_e          qr_state;
  logic [LINE_W-1:0] cand_line;

  // control
  logic              wake_q, wake_d;
  logic              replay_go, blocked, slot_free, issue;
  logic              iss_write;
  logic [LINE_W-1:0] iss_line;
  logic [DATA_W-1:0] iss_wdata;
  logic              done;

  assign replay_go = wake_q && !pk_empty;
  assign cand_line = replay_go ? h_line : req_line;
  assign blocked   = qa_busy || tbl_full;
  assign slot_free = !mem_valid || mem_ready;

  always_comb begin
    issue     = 1'b0;
    pk_push   = 1'b0;
    pk_pop    = 1'b0;
    req_ready = 1'b0;
    iss_write = req_write;
    iss_line  = req_line;
    iss_wdata = req_wdata;
    if (replay_go) begin
      iss_write = h_write;
      iss_line  = h_line;
      iss_wdata = h_wdata;
      if (!blocked && slot_free) begin
        issue  = 1'b1;
        pk_pop = 1'b1;
      end
    end else if (!pk_empty) begin
      req_ready = !pk_full;
      pk_push   = req_valid && !pk_full;
    end else if (blocked) begin
      req_ready = 1'b1;
      pk_push   = req_valid;
    end else begin
      req_ready = slot_free;
      issue     = req_valid && slot_free;
    end
  end

  // response matching
  assign rsp_ready = 1'b1;
  assign done = rsp_valid && qr_hit &&
                ((rsp_is_data && qr_state == LN_RD_WAIT) ||
                 (!rsp_is_data && qr_state == LN_WR_WAIT));

  always_comb begin
    if (done)                       wake_d = 1'b1;
    else if (replay_go && blocked)  wake_d = 1'b0;
    else if (pk_empty)              wake_d = 1'b0;
    else                            wake_d = wake_q;
  end

  dlc_park_fifo #(.DEPTH(PARK_DEPTH), .W(PK_W)) u_park (
    .clk(clk), .rst_n(rst_n),
    .push(pk_push), .push_data({req_write, req_line, req_wdata}),
    .pop(pk_pop), .head(pk_head), .empty(pk_empty), .full(pk_full)
  );

  dlc_line_table #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(issue), .alloc_write(iss_write), .alloc_line(iss_line),
    .free_en(done), .free_idx(qr_idx),
    .qa_line(cand_line), .qa_busy(qa_busy),
    .qr_line(rsp_line), .qr_hit(qr_hit), .qr_idx(qr_idx), .qr_state(qr_state),
    .full(tbl_full)
  );

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q    <= 1'b0;
      mem_valid <= 1'b0;
      mem_write <= 1'b0;
      mem_line  <= '0;
      mem_wdata <= '0;
      cb_valid  <= 1'b0;
      cb_write  <= 1'b0;
      cb_line   <= '0;
      cb_data   <= '0;
      resp_err  <= 1'b0;
    end else begin
      wake_q   <= wake_d;
      cb_valid <= done;
      resp_err <= rsp_valid && !done;
      if (issue) begin
        mem_valid <= 1'b1;
        mem_write <= iss_write;
        mem_line  <= iss_line;
        mem_wdata <= iss_write ? iss_wdata : '0;
      end else if (mem_ready) begin
        mem_valid <= 1'b0;
      end
      if (done) begin
        cb_write <= !rsp_is_data;
        cb_line  <= rsp_line;
        cb_data  <= rsp_is_data ? rsp_data : '0;
      end
    end
  end
endmodule

// File: rtl/dlc_checker.sv
module dlc_checker #(
  parameter int LINE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [LINE_W-1:0] mem_line,
  input logic              rsp_valid,
  input logic [LINE_W-1:0] rsp_line,
  input logic              cb_valid,
  input logic [LINE_W-1:0] cb_line,
  input logic              resp_err
);
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_line) && $stable(mem_write))); // R3

  AST_CB_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    cb_valid |-> $past(rsp_valid)); // R10

  AST_CB_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    cb_valid |-> (cb_line == $past(rsp_line))); // R4

  AST_ERR_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> $past(rsp_valid)); // R8

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_err && cb_valid)); // R8
endmodule

bind dma_line_ctrl dlc_checker #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
  .mem_line(mem_line), .rsp_valid(rsp_valid), .rsp_line(rsp_line),
  .cb_valid(cb_valid), .cb_line(cb_line), .resp_err(resp_err)
);

// File: tb/sim_dma_line_ctrl.sv
`timescale 1ns/1ps
module sim_dma_line_ctrl;
  localparam int LW = 16;
  localparam int DW = 32;

  logic clk, rst_n;
  logic req_valid, req_ready, req_write;
  logic [LW-1:0] req_line;
  logic [DW-1:0] req_wdata;
  logic mem_valid, mem_ready, mem_write;
  logic [LW-1:0] mem_line;
  logic [DW-1:0] mem_wdata;
  logic rsp_valid, rsp_ready, rsp_is_data;
  logic [LW-1:0] rsp_line;
  logic [DW-1:0] rsp_data;
  logic cb_valid, cb_write;
  logic [LW-1:0] cb_line;
  logic [DW-1:0] cb_data;
  logic resp_err;

  int n_chk = 0;
  int n_fail = 0;

  dma_line_ctrl #(.LINE_W(LW), .DATA_W(DW), .ENTRIES(4), .PARK_DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_line(req_line), .req_wdata(req_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_line(mem_line), .mem_wdata(mem_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_is_data(rsp_is_data),
    .rsp_line(rsp_line), .rsp_data(rsp_data),
    .cb_valid(cb_valid), .cb_write(cb_write), .cb_line(cb_line),
    .cb_data(cb_data), .resp_err(resp_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {write, line, data}
  localparam logic [48:0] VEC [6] = '{
    {1'b0, 16'h0011, 32'hA5A5_0001},
    {1'b1, 16'h0012, 32'h1234_5678},
    {1'b0, 16'hFFFF, 32'hDEAD_BEEF},
    {1'b1, 16'h0000, 32'h0000_0001},
    {1'b0, 16'h8000, 32'h7FFF_FFFF},
    {1'b1, 16'h0011, 32'hCAFE_F00D}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic send_req(input logic w, input logic [LW-1:0] l, input logic [DW-1:0] d);
    req_valid = 1'b1; req_write = w; req_line = l; req_wdata = d;
    step();
    req_valid = 1'b0;
  endtask

  task automatic send_rsp(input logic isd, input logic [LW-1:0] l, input logic [DW-1:0] d);
    rsp_valid = 1'b1; rsp_is_data = isd; rsp_line = l; rsp_data = d;
    step();
    rsp_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_line = 0; req_wdata = 0;
    mem_ready = 1'b1; rsp_valid = 0; rsp_is_data = 0; rsp_line = 0; rsp_data = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 mem_valid in reset", mem_valid, 0);
    chk("R1 cb_valid in reset", cb_valid, 0);
    rst_n = 1'b1;
    step();
    chk("R1 mem_valid", mem_valid, 0);
    chk("R1 cb_valid", cb_valid, 0);
    chk("R1 resp_err", resp_err, 0);
    chk("R1 req_ready", req_ready, 1);

    // vector table: issue then complete
    for (int i = 0; i < 6; i++) begin
      logic w; logic [LW-1:0] l; logic [DW-1:0] d;
      {w, l, d} = VEC[i];
      send_req(w, l, d);
      chk("R2 mem_valid", mem_valid, 1);
      chk("R2 mem_line", mem_line, l);
      chk("R2 mem_write", mem_write, w);
      if (w) chk("R2 mem_wdata", mem_wdata, d);
      send_rsp(!w, l, d);
      chk(w ? "R5 cb_valid" : "R4 cb_valid", cb_valid, 1);
      chk(w ? "R5 cb_write" : "R4 cb_write", cb_write, w);
      chk(w ? "R5 cb_line" : "R4 cb_line", cb_line, l);
      if (!w) chk("R4 cb_data", cb_data, d);
      step();
      chk("R10 cb pulse ends", cb_valid, 0);
    end

    // R3 hold under backpressure
    mem_ready = 1'b0;
    send_req(1'b0, 16'd5, 0);
    chk("R3 valid", mem_valid, 1);
    step();
    step();
    chk("R3 held valid", mem_valid, 1);
    chk("R3 held line", mem_line, 16'd5);
    mem_ready = 1'b1;
    step();
    chk("R3 drained", mem_valid, 0);
    send_rsp(1'b1, 16'd5, 32'h55);
    chk("R4 cb after hold", cb_line, 16'd5);

    // R6 / R9 parking and ordered replay
    send_req(1'b0, 16'd7, 0);
    chk("R2 read 7 issued", mem_valid, 1);
    send_req(1'b1, 16'd7, 32'h77);
    chk("R6 busy write parked", mem_valid, 0);
    send_req(1'b0, 16'd7, 0);
    send_req(1'b0, 16'd9, 0);
    chk("R6 nothing issued while parked", mem_valid, 0);
    send_rsp(1'b1, 16'd7, 32'hD7);
    chk("R4 read 7 done", cb_valid, 1);
    step();
    chk("R9 replay 1 valid", mem_valid, 1);
    chk("R9 replay 1 is write", mem_write, 1);
    chk("R9 replay 1 data", mem_wdata, 32'h77);
    step();
    chk("R9 halt at busy head", mem_valid, 0);
    step();
    chk("R9 line 9 stays parked", mem_valid, 0);
    send_rsp(1'b0, 16'd7, 0);
    chk("R5 write 7 done", cb_write, 1);
    step();
    chk("R9 replay 2 line", mem_line, 16'd7);
    chk("R9 replay 2 read", mem_write, 0);
    step();
    chk("R9 replay 3 line", mem_line, 16'd9);
    chk("R9 replay 3 valid", mem_valid, 1);
    step();
    chk("R9 queue drained", mem_valid, 0);
    send_rsp(1'b1, 16'd7, 1);
    send_rsp(1'b1, 16'd9, 2);
    chk("R4 line 9 done", cb_line, 16'd9);

    // R7 table full
    for (int i = 0; i < 4; i++) begin
      send_req(1'b0, LW'(20 + i), 0);
      chk("R7 fill", mem_line, LW'(20 + i));
    end
    send_req(1'b0, 16'd24, 0);
    chk("R7 full parks", mem_valid, 0);
    send_rsp(1'b1, 16'd21, 32'h21);
    chk("R7 still parked at completion", mem_valid, 0);
    step();
    chk("R7 issued after free", mem_valid, 1);
    chk("R7 issued line", mem_line, 16'd24);
    send_rsp(1'b1, 16'd20, 0);
    send_rsp(1'b1, 16'd22, 0);
    send_rsp(1'b1, 16'd23, 0);
    send_rsp(1'b1, 16'd24, 0);
    chk("R4 drain", cb_line, 16'd24);

    // R8 unmatched responses
    send_rsp(1'b1, 16'd30, 0);
    chk("R8 err no entry", resp_err, 1);
    chk("R8 no cb", cb_valid, 0);
    send_req(1'b1, 16'd31, 32'h31);
    chk("R8 err one cycle", resp_err, 0);
    send_rsp(1'b1, 16'd31, 0);
    chk("R8 err wrong type", resp_err, 1);
    chk("R8 no cb wrong type", cb_valid, 0);
    send_rsp(1'b0, 16'd31, 0);
    chk("R8 entry kept", cb_valid, 1);
    chk("R8 no err on match", resp_err, 0);

    // R11 line reusable
    send_req(1'b0, 16'd31, 0);
    chk("R11 reissue valid", mem_valid, 1);
    chk("R11 reissue line", mem_line, 16'd31);
    send_rsp(1'b1, 16'd31, 32'h99);
    chk("R11 done", cb_data, 32'h99);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule